// File: doc/BRIEF.md
# Bunch-by-Bunch Turn-Axis Feedback Filter

This block computes a transverse correction for every bunch in a storage ring. Beam-position samples arrive as a stream of beats. Each beat holds four signed 12-bit samples, one per lane. The lanes cover four neighbouring bunch slots, so a 500 Msps sample stream is carried at a quarter of that rate. The block tracks which slots each beat belongs to and keeps a separate shift register of past turns for every slot. It filters each slot along the turn axis, not along neighbouring samples. It then scales the result by a gain that a host can program, rounds it, clamps it to the converter width, and sends four corrected samples per beat to the output stream.

Both streams use valid/ready. An input beat is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high when the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output beat is held unchanged and no input is accepted. Coefficients and gain are written through a plain address/data/write-enable port. Writes are staged, and take effect when the next turn begins, so a turn never mixes two filter settings.

Top module: `bbfb_proc`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1. All coefficients and the gain are 0, and every slot's turn history and its count of collected turns are cleared. A reset in mid-run therefore restarts the warm-up of R7 for every slot.
- R2: Lane k of a beat (bits [12k+11:12k], two's complement) carries slot 4b+k. Here b is the beat index within the turn. A beat with `s_turn` high has b = 0. Otherwise b is one more than the previous accepted beat's index, and it wraps from N/4-1 back to 0 with N = 16 slots.
- R3: For the turn t sample of slot s, the filtered value is the sum over taps j = 0..7 of c[j] times slot s's sample from turn t-j. Tap 0 is the sample in the current beat. Each slot uses only its own history.
- R4: Coefficients have 14 fraction bits (16384 = 1.0) and the gain has 8 fraction bits (256 = 1.0). The output equals the filtered value times the gain, divided by 2^22.
- R5: That division rounds to nearest, and ties go toward positive infinity. For example, 1.5 gives 2 and -1.5 gives -1.
- R6: The result is saturated to the signed 12-bit range -2048..2047 and never wraps.
- R7: A slot's output is 0 until the slot has 7 earlier accepted samples. Its 8th accepted sample is the first one that gives a filtered output.
- R8: Register map: addresses 0..7 write signed tap coefficients c[0]..c[7], and address 8 writes the signed gain. Writes to addresses 9..15 have no effect.
- R9: A register write becomes active on the next accepted beat that starts a turn (b = 0), and that beat already uses it. Beats before it keep the old values.
- R10: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0 and `m_data` holds steady. A beat offered during that time does not change any slot history until it is accepted.
- R11: The result for a beat accepted at a clock edge appears on `m_data` with `m_valid` = 1 right after that edge. `m_valid` returns to 0 after a drained cycle in which no new beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be accepted |
| s_turn | input | 1 | Beat is the first of a revolution (slot 0 in lane 0) |
| s_data | input | 48 | Four signed 12-bit samples, lane k at bits [12k+11:12k] |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 48 | Four signed 12-bit corrections, lane k at bits [12k+11:12k] |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0..7 taps, 8 gain) |
| cfg_wdata | input | 16 | Signed register value |

## Verification
The directed scenarios target the following corner cases:
- Warm-up edge: a design that counts turns globally instead of per slot, or counts off by one, makes output appear one turn early or late.
- Turn marker in mid-turn: a design that ignores the marker files samples into the wrong slot histories.
- Coefficient write part-way through a turn: a design without staging changes the remaining beats of that turn.
- Rounding ties and full-scale overflow: these expose a truncating or wrapping output stage.
- Back-pressure: this catches a design that lets a stalled beat leak into a history, or changes the held output.
- Reset in mid-run: this catches histories that survive reset and give output before eight turns.

// File: rtl/bbfb_pkg.sv
package bbfb_pkg;
  // the stream carries four adjacent bunch slots per beat
  localparam int LANES = 4;
  localparam int LANE_BITS = 2;
endpackage

// File: rtl/bbfb_cfg.sv
module bbfb_cfg #(
  parameter int TAPS   = 8,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CFG_W-1:0]            wdata,
  input  logic                        turn_go,
  output logic [TAPS-1:0][CFG_W-1:0]  coef_o,
  output logic [CFG_W-1:0]            gain_o
);
  logic [TAPS-1:0][CFG_W-1:0] coef_sh, coef_act;
  logic [CFG_W-1:0]           gain_sh, gain_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_sh  <= '0;
      coef_act <= '0;
      gain_sh  <= '0;
      gain_act <= '0;
    end else begin
      for (int j = 0; j < TAPS; j++) begin
        if (we && addr == ADDR_W'(j)) coef_sh[j] <= wdata;
      end
      if (we && addr == ADDR_W'(TAPS)) gain_sh <= wdata;
      if (turn_go) begin
        coef_act <= coef_sh;
        gain_act <= gain_sh;
      end
    end
  end

  // the beat opening a turn already sees the staged set
  assign coef_o = turn_go ? coef_sh : coef_act;
  assign gain_o = turn_go ? gain_sh : gain_act;

  // R9: active settings move only at an accepted turn start
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_go |=> $stable(coef_act) && $stable(gain_act));
endmodule

// File: rtl/bbfb_hist.sv
module bbfb_hist
  import bbfb_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int TAPS  = 8,
  parameter int IN_W  = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              accept,
  input  logic                              turn_in,
  input  logic [LANES-1:0][IN_W-1:0]        samp,
  output logic [TAPS-2:0][IN_W-1:0]         past_o [LANES],
  output logic [LANES-1:0]                  win_o,
  output logic                              turn_go
);
  localparam int NB   = NSLOT / LANES;
  localparam int CW   = (NB > 1) ? $clog2(NB) : 1;
  localparam int SW   = CW + LANE_BITS;
  localparam int FW   = $clog2(TAPS);
  localparam logic [CW-1:0] NEXT0 = (NB > 1) ? CW'(1) : CW'(0);

  logic [CW-1:0]              cnt, base;
  logic [TAPS-2:0][IN_W-1:0]  mem  [NSLOT];
  logic [FW-1:0]              fill [NSLOT];

  assign base    = turn_in ? '0 : cnt;
  assign turn_go = accept && (base == '0);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [SW-1:0] idx;
      idx       = {base, LANE_BITS'(k)};
      past_o[k] = mem[idx];
      win_o[k]  = (fill[idx] == FW'(TAPS - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= (base == CW'(NB - 1)) ? '0 : base + CW'(1);
    end
  end

  // one shift register of past turns per slot; only the addressed group moves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        mem[s]  <= '0;
        fill[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (accept && CW'(s / LANES) == base) begin
          mem[s][0] <= samp[s % LANES];
          for (int j = 1; j < TAPS - 1; j++) mem[s][j] <= mem[s][j-1];
          if (fill[s] != FW'(TAPS - 1)) fill[s] <= fill[s] + FW'(1);
        end
      end
    end
  end

  // R2: a marked beat is slot group 0, so the next group is 1
  p_turn_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && turn_in |=> cnt == NEXT0);
endmodule

// File: rtl/bbfb_lane.sv
module bbfb_lane #(
  parameter int TAPS      = 8,
  parameter int IN_W      = 12,
  parameter int CFG_W     = 16,
  parameter int OUT_W     = 12,
  parameter int COEF_FRAC = 14,
  parameter int GAIN_FRAC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IN_W-1:0]             x,
  input  logic [TAPS-2:0][IN_W-1:0]   past,
  input  logic [TAPS-1:0][CFG_W-1:0]  coef,
  input  logic [CFG_W-1:0]            gain,
  input  logic                        win_ok,
  output logic [OUT_W-1:0]            y
);
  localparam int ACC_W = IN_W + CFG_W + $clog2(TAPS);
  localparam int PW    = ACC_W + CFG_W + 1;
  localparam int SH    = COEF_FRAC + GAIN_FRAC;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [ACC_W-1:0] acc;
  logic signed [PW-1:0]    prod, rnd, q;

  always_comb begin
    acc = ACC_W'($signed(coef[0])) * ACC_W'($signed(x));
    for (int j = 1; j < TAPS; j++) begin
      acc = acc + ACC_W'($signed(coef[j])) * ACC_W'($signed(past[j-1]));
    end
    prod = PW'(acc) * PW'($signed(gain));
    rnd  = prod + HALF;
    q    = rnd >>> SH;
    if (!win_ok)       y = '0;
    else if (q > MAXV) y = MAXV[OUT_W-1:0];
    else if (q < MINV) y = MINV[OUT_W-1:0];
    else               y = q[OUT_W-1:0];
  end

  // R6: a positive product never comes out negative
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok && (prod > 0) |-> !y[OUT_W-1]);
endmodule

// File: rtl/bbfb_proc.sv
module bbfb_proc
  import bbfb_pkg::*;
#(
  parameter int NSLOT     = 16,
  parameter int TAPS      = 8,
  parameter int IN_W      = 12,
  parameter int OUT_W     = 12,
  parameter int CFG_W     = 16,
  parameter int COEF_FRAC = 14,
  parameter int GAIN_FRAC = 8,
  localparam int ADDR_W   = $clog2(TAPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic                    s_turn,
  input  logic [LANES*IN_W-1:0]   s_data,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [LANES*OUT_W-1:0]  m_data,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata
);
  logic                        accept, turn_go;
  logic [LANES-1:0][IN_W-1:0]  samp;
  logic [TAPS-2:0][IN_W-1:0]   past [LANES];
  logic [LANES-1:0]            win_ok;
  logic [TAPS-1:0][CFG_W-1:0]  coef;
  logic [CFG_W-1:0]            gain;
  logic [LANES-1:0][OUT_W-1:0] y, out_q;

  assign samp    = s_data;
  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;
  assign m_data  = out_q;

  bbfb_cfg #(.TAPS(TAPS), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .turn_go(turn_go), .coef_o(coef), .gain_o(gain)
  );

  bbfb_hist #(.NSLOT(NSLOT), .TAPS(TAPS), .IN_W(IN_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .accept(accept), .turn_in(s_turn), .samp(samp),
    .past_o(past), .win_o(win_ok), .turn_go(turn_go)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bbfb_lane #(
      .TAPS(TAPS), .IN_W(IN_W), .CFG_W(CFG_W), .OUT_W(OUT_W),
      .COEF_FRAC(COEF_FRAC), .GAIN_FRAC(GAIN_FRAC)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .x(samp[k]), .past(past[k]), .coef(coef),
      .gain(gain), .win_ok(win_ok[k]), .y(y[k])
    );

    // R7: a slot without a full window emits zero
    p_warm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !win_ok[k] |=> out_q[k] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      out_q   <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      out_q   <= y;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R10: a stalled output beat stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  // R11: an accepted beat is visible after one edge
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid);
endmodule

// File: tb/bbfb_proc_tb.sv
module bbfb_proc_tb;
  logic        clk = 0, rst_n = 0;
  logic        s_valid = 0, s_turn = 0, m_ready = 1, cfg_we = 0;
  logic        s_ready, m_valid;
  logic [47:0] s_data = '0;
  logic [47:0] m_data;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int mh [16][7];
  int mf [16];
  int csh [8], cact [8];
  int gsh, gact, mcnt;

  always #5 clk = ~clk;

  bbfb_proc u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_turn(s_turn), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(bit ok, string tag, logic [48:0] act, logic [48:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      mf[s] = 0;
      for (int j = 0; j < 7; j++) mh[s][j] = 0;
    end
    for (int j = 0; j < 8; j++) begin csh[j] = 0; cact[j] = 0; end
    gsh = 0; gact = 0; mcnt = 0;
  endtask

  function automatic int out_of(int s, int x);
    longint acc, p, q;
    if (mf[s] < 7) return 0;
    acc = longint'(cact[0]) * x;
    for (int j = 1; j < 8; j++) acc += longint'(cact[j]) * mh[s][j-1];
    p = acc * gact;
    q = (p + (longint'(1) << 21)) >>> 22;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return int'(q);
  endfunction

  // expected result for a beat accepted now, and model update
  function automatic logic [47:0] model_beat(bit turn, int d [4]);
    logic [47:0] e;
    int base;
    base = turn ? 0 : mcnt;
    if (base == 0) begin
      for (int j = 0; j < 8; j++) cact[j] = csh[j];
      gact = gsh;
    end
    for (int k = 0; k < 4; k++) begin
      int s;
      s = base * 4 + k;
      e[k*12 +: 12] = 12'(out_of(s, d[k]));
      for (int j = 6; j > 0; j--) mh[s][j] = mh[s][j-1];
      mh[s][0] = d[k];
      if (mf[s] < 7) mf[s]++;
    end
    mcnt = (base + 1) % 4;
    return e;
  endfunction

  task automatic drive(bit turn, int d [4]);
    s_valid = 1;
    s_turn  = turn;
    for (int k = 0; k < 4; k++) s_data[k*12 +: 12] = 12'(d[k]);
  endtask

  task automatic beat(bit turn, int d0, int d1, int d2, int d3, string tag);
    int d [4];
    logic [47:0] e;
    d = '{d0, d1, d2, d3};
    @(negedge clk);
    drive(turn, d);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 0;
    e = model_beat(turn, d);
    check(m_valid === 1'b1 && m_data === e, tag, {m_valid, m_data}, {1'b1, e});
  endtask

  task automatic wr(int a, int v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 16'(v);
    @(posedge clk);
    #1;
    cfg_we = 0;
    if (a < 8) csh[a] = v;
    else if (a == 8) gsh = v;
  endtask

  task automatic set_c0(int c0, int g);
    wr(0, c0);
    for (int j = 1; j < 8; j++) wr(j, 0);
    wr(8, g);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_turns(int n, int off, string early, string late);
    for (int t = 0; t < n; t++) begin
      for (int b = 0; b < 4; b++) begin
        int s0;
        s0 = b * 4;
        beat(b == 0, s0 * 7 + t * 3 + off, (s0 + 1) * 7 + t * 3 + off,
             (s0 + 2) * 7 - t * 5 + off, (s0 + 3) * 7 + t + off,
             (t < 7) ? early : late);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(m_valid === 1'b0, "R1 m_valid", {48'd0, m_valid}, 49'd0);
    check(s_ready === 1'b1, "R1 s_ready", {48'd0, s_ready}, 49'd1);
  endtask

  task automatic t_warmup();
    set_c0(16384, 256);
    run_turns(8, 1, "R7 warm-up zero", "R7 first filtered turn");
  endtask

  task automatic t_fir();
    wr(0, 16384); wr(1, -8192); wr(2, 4096); wr(7, 2048);
    run_turns(3, -40, "R3 turn-axis FIR", "R3 turn-axis FIR");
  endtask

  task automatic t_stage();
    beat(1, 10, 20, 30, 40, "R9 turn start");
    beat(0, 11, 21, 31, 41, "R9 before write");
    wr(0, 8192);
    wr(3, -3000);
    beat(0, 12, 22, 32, 42, "R9 old set after write");
    beat(0, 13, 23, 33, 43, "R9 old set after write");
    beat(0, 14, 24, 34, 44, "R9 new set on boundary");
    beat(0, 15, 25, 35, 45, "R9 new set holds");
  endtask

  task automatic t_marker();
    beat(1, 100, 101, 102, 103, "R2 marked beat");
    beat(0, 104, 105, 106, 107, "R2 second group");
    beat(1, 200, 201, 202, 203, "R2 early marker");
    beat(0, 204, 205, 206, 207, "R2 after marker");
    beat(0, 208, 209, 210, 211, "R2 third group");
    beat(0, 212, 213, 214, 215, "R2 last group");
    beat(0, 216, 217, 218, 219, "R2 wrap without marker");
  endtask

  task automatic t_round();
    set_c0(8192, 256);
    beat(1, 3, -3, 5, -5, "R5 ties toward plus");
  endtask

  task automatic t_gain();
    set_c0(16384, 512);
    beat(1, 100, -100, 7, 0, "R4 gain 2.0");
    wr(8, -256);
    beat(1, 100, -100, 7, 0, "R4 gain -1.0");
  endtask

  task automatic t_sat();
    set_c0(32767, 32767);
    beat(1, 2047, -2048, 1, 0, "R6 saturate");
    beat(0, -1, 2, -2047, 3, "R6 saturate");
  endtask

  task automatic t_ignored();
    set_c0(16384, 256);
    for (int a = 9; a < 16; a++) wr(a, 32767);
    beat(1, 50, -60, 70, -80, "R8 unmapped writes");
  endtask

  task automatic t_backpressure();
    int d [4];
    logic [47:0] held, e;
    beat(1, 300, 301, 302, 303, "R10 pre-stall");
    m_ready = 0;
    held = m_data;
    d = '{400, 401, 402, 403};
    @(negedge clk);
    drive(0, d);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(s_ready === 1'b0 && m_valid === 1'b1 && m_data === held,
            "R10 stall hold", {s_ready, m_data}, {1'b0, held});
    end
    m_ready = 1;
    @(posedge clk);
    #1;
    s_valid = 0;
    e = model_beat(0, d);
    check(m_valid === 1'b1 && m_data === e, "R10 accept after stall",
          {m_valid, m_data}, {1'b1, e});
    @(posedge clk);
    #1;
    check(m_valid === 1'b0, "R11 valid drops", {48'd0, m_valid}, 49'd0);
    beat(0, 500, 501, 502, 503, "R10 history untouched");
    beat(0, 504, 505, 506, 507, "R11 next beat");
  endtask

  task automatic t_reset_mid();
    do_reset();
    set_c0(16384, 256);
    run_turns(8, 9, "R1 cleared history", "R1 refilled");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    t_reset();
    t_warmup();
    t_fir();
    t_stage();
    t_marker();
    t_round();
    t_gain();
    t_sat();
    t_ignored();
    t_backpressure();
    t_reset_mid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule